// File: doc/BRIEF.md
# Scan Chain Across Skewed Clock Domains

This block is a scan chain built from several segments. Each segment is a run of mux-D scan cells on one clock, and each segment has its own clock, which fires on either the rising or the falling edge. In functional mode every cell loads its own functional input bit. In scan mode the cells form one serial path from `scan_in` to `scan_out`. A chip uses this path to load and unload test state one bit per clock period.

The clocks of the segments have the same period, but their relative skew is not controlled. The chain therefore fixes how data crosses from one segment to the next:
- **Lock-up latch.** Between two segments that use the same edge type, a lock-up latch holds the launched bit for the inactive half of the launching clock. A capturing clock that lags the launching clock therefore still sees the previous bit.
- **Segment ordering.** By default the chain places all falling-edge segments ahead of all rising-edge segments. Each crossing from falling to rising then has half a period of margin by construction.
- **Retiming flop.** When the user keeps the index order instead, every crossing from a rising segment into a falling segment gets a retiming flop on the falling clock. This keeps the bit from being shifted twice in one period.
- **End latch.** An optional lock-up latch can follow the last cell.

Top module: `scan_xdom_chain`

In the requirements below, a "period" runs from one sample point to the next. The sample point lies after the falling edges of all domains and before the first rising edge of the next period. Inputs change, and outputs are read, at that point.

## Requirements
- R1: At its segment's active edge, each cell loads the previous chain element when `scan_enable` is 1, and loads its own `func_in` bit when `scan_enable` is 0. Bit s*SEG_LEN+j of `func_in` and `func_out` belongs to cell j of segment s. Cell 0 is the cell nearest the chain input. SEG_FALL[s]=1 selects the falling edge for segment s, and 0 selects the rising edge.
- R2: Between consecutive segments with the same edge type, a lock-up latch is clocked by the launching segment's clock. The latch is transparent while that clock is in its inactive phase: low for a rising segment, high for a falling segment. Shifting stays bit-exact when the capturing clock lags the launching clock by up to a quarter period.
- R3: With ORDER_BY_EDGE=1, the chain runs through all falling-edge segments in ascending index, then through all rising-edge segments in ascending index.
- R4: With ORDER_BY_EDGE=0, the chain runs through the segments in ascending index. A rising-to-falling crossing gets a retiming flop on the falling segment's clock, and a falling-to-rising crossing is a direct wire. No bit is lost or duplicated.
- R5: A bit applied to `scan_in` with `scan_enable`=1 appears at `scan_out` after exactly NSEG*SEG_LEN periods. Lock-up latches and retiming flops add no periods.
- R6: With END_LOCKUP=1, a lock-up latch follows the final cell. It uses that cell's clock and the phase rule of R2, and it adds no period of latency.
- R7: A synchronous active-high `rst` clears every cell and every retiming flop at its domain's active edge. After that, `func_out` and `scan_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| seg_clk | input | NSEG | One clock per segment, indexed by segment number |
| rst | input | 1 | Synchronous active-high reset, applied in every domain |
| scan_enable | input | 1 | 1 selects shifting, 0 selects functional capture |
| scan_in | input | 1 | Serial input at the head of the chain |
| func_in | input | NSEG*SEG_LEN | Functional data, one bit per cell |
| func_out | output | NSEG*SEG_LEN | Current state of every cell |
| scan_out | output | 1 | Serial output at the tail of the chain |

## Verification
Assertions check the following on every active edge:
- each segment's reaction to shift, capture and reset;
- that each lock-up latch is still transparent, and matches its input, when its launching clock reaches the active edge.

Three properties concern the chain as a whole rather than one stage:
- the order in which segments are joined;
- the equal latency across latches and retiming flops;
- bit-exact recovery when capture clocks lag launch clocks.

Only the bench scenarios can show these. The bench runs two chain variants under skewed clocks. It tracks `func_out` and `scan_out` against a chain-order model every period. It also checks the period in which a lone injected bit, or a single captured bit, reaches the tail.

// File: rtl/scan_xdom_pkg.sv
package scan_xdom_pkg;

    localparam int MAX_SEGS = 32;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;

    typedef enum logic [1:0] {
        JOIN_DIRECT,
        JOIN_LOCKUP,
        JOIN_RETIME
    } join_e;

    typedef logic [MAX_SEGS-1:0] edge_map_t;

    // Segment index found at chain position pos.
    function automatic int chain_seg(int pos, int nseg, edge_map_t fall_map, bit by_edge);
        int found;
        int rank;
        found = pos;
        rank  = 0;
        if (by_edge) begin
            found = 0;
            for (int pass = 0; pass < 2; pass++) begin
                for (int s = 0; s < MAX_SEGS; s++) begin
                    if (s < nseg && fall_map[s] == (pass == 0)) begin
                        if (rank == pos) found = s;
                        rank++;
                    end
                end
            end
        end
        return found;
    endfunction

    function automatic edge_e seg_edge(int s, edge_map_t fall_map);
        return fall_map[s] ? EDGE_FALL : EDGE_RISE;
    endfunction

    // How a launching segment is joined to the capturing one.
    function automatic join_e join_kind(edge_e launch, edge_e capture);
        join_e k;
        if (launch == capture)
            k = JOIN_LOCKUP;
        else if (launch == EDGE_RISE)
            k = JOIN_RETIME;
        else
            k = JOIN_DIRECT;
        return k;
    endfunction

endpackage

// File: rtl/lockup_latch.sv
module lockup_latch
    import scan_xdom_pkg::*;
#(
    parameter edge_e EDGE = EDGE_RISE
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    // Active clock: its rising edge is the launching edge.
    logic act_clk;
    logic held;

    assign act_clk = (EDGE == EDGE_FALL) ? ~clk : clk;

    // Open in the inactive phase of the launching clock.
    always_latch begin
        if (!act_clk) held <= d;
    end

    assign q = held;

    AST_LOCKUP_TRACKS: assert property (@(posedge act_clk) disable iff (rst)
        q == d); // R2

endmodule

// File: rtl/retime_flop.sv
module retime_flop
    import scan_xdom_pkg::*;
#(
    parameter edge_e EDGE = EDGE_FALL
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic act_clk;
    logic stage_q;

    assign act_clk = (EDGE == EDGE_FALL) ? ~clk : clk;

    always_ff @(posedge act_clk) begin
        if (rst) stage_q <= 1'b0;
        else     stage_q <= d;
    end

    assign q = stage_q;

    AST_RETIME_CLEARS: assert property (@(posedge act_clk)
        rst |=> (q == 1'b0)); // R7

endmodule

// File: rtl/scan_seg.sv
module scan_seg
    import scan_xdom_pkg::*;
#(
    parameter int    LEN  = 4,
    parameter edge_e EDGE = EDGE_RISE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           se,
    input  logic           si,
    input  logic [LEN-1:0] fin,
    output logic [LEN-1:0] fout,
    output logic           so
);

    logic           act_clk;
    logic [LEN-1:0] cell_q;
    logic [LEN-1:0] cell_d;
    logic [LEN-1:0] shift_src;

    assign act_clk = (EDGE == EDGE_FALL) ? ~clk : clk;

    if (LEN == 1) begin : g_single
        assign shift_src = si;
    end else begin : g_multi
        assign shift_src = {cell_q[LEN-2:0], si};
    end

    // Mux-D select per cell.
    always_comb begin
        cell_d = se ? shift_src : fin;
    end

    always_ff @(posedge act_clk) begin
        if (rst) cell_q <= '0;
        else     cell_q <= cell_d;
    end

    assign fout = cell_q;
    assign so   = cell_q[LEN-1];

    AST_SEG_RESET: assert property (@(posedge act_clk)
        rst |=> (cell_q == '0)); // R7

    AST_SEG_CAPTURE: assert property (@(posedge act_clk) disable iff (rst)
        !se |=> (cell_q == $past(fin))); // R1

    AST_SEG_HEAD: assert property (@(posedge act_clk) disable iff (rst)
        se |=> (cell_q[0] == $past(si))); // R1

    if (LEN > 1) begin : g_body_chk
        AST_SEG_BODY: assert property (@(posedge act_clk) disable iff (rst)
            se |=> (cell_q[LEN-1:1] == $past(cell_q[LEN-2:0]))); // R1
    end

endmodule

// File: rtl/scan_xdom_chain.sv
module scan_xdom_chain
    import scan_xdom_pkg::*;
#(
    parameter int              NSEG          = 4,
    parameter int              SEG_LEN       = 3,
    parameter logic [NSEG-1:0] SEG_FALL      = 4'b0101,
    parameter bit              ORDER_BY_EDGE = 1'b1,
    parameter bit              END_LOCKUP    = 1'b1
) (
    input  logic [NSEG-1:0]         seg_clk,
    input  logic                    rst,
    input  logic                    scan_enable,
    input  logic                    scan_in,
    input  logic [NSEG*SEG_LEN-1:0] func_in,
    output logic [NSEG*SEG_LEN-1:0] func_out,
    output logic                    scan_out
);

    localparam edge_map_t FALL_MAP = edge_map_t'(SEG_FALL);
    localparam int        LAST_SEG = chain_seg(NSEG - 1, NSEG, FALL_MAP, ORDER_BY_EDGE);
    localparam edge_e     LAST_EDG = seg_edge(LAST_SEG, FALL_MAP);

    // Indexed by chain position, not by segment number.
    logic [NSEG-1:0] seg_in;
    logic [NSEG-1:0] seg_out;

    for (genvar p = 0; p < NSEG; p++) begin : g_pos
        localparam int    S = chain_seg(p, NSEG, FALL_MAP, ORDER_BY_EDGE);
        localparam edge_e E = seg_edge(S, FALL_MAP);

        scan_seg #(
            .LEN  (SEG_LEN),
            .EDGE (E)
        ) u_seg (
            .clk  (seg_clk[S]),
            .rst  (rst),
            .se   (scan_enable),
            .si   (seg_in[p]),
            .fin  (func_in[S*SEG_LEN +: SEG_LEN]),
            .fout (func_out[S*SEG_LEN +: SEG_LEN]),
            .so   (seg_out[p])
        );

        if (p == 0) begin : g_head
            assign seg_in[p] = scan_in;
        end else begin : g_join
            localparam int    PS = chain_seg(p - 1, NSEG, FALL_MAP, ORDER_BY_EDGE);
            localparam edge_e PE = seg_edge(PS, FALL_MAP);
            localparam join_e J  = join_kind(PE, E);

            if (J == JOIN_LOCKUP) begin : g_lock
                lockup_latch #(.EDGE(PE)) u_lock (
                    .clk (seg_clk[PS]),
                    .rst (rst),
                    .d   (seg_out[p-1]),
                    .q   (seg_in[p])
                );
            end else if (J == JOIN_RETIME) begin : g_retime
                retime_flop #(.EDGE(E)) u_retime (
                    .clk (seg_clk[S]),
                    .rst (rst),
                    .d   (seg_out[p-1]),
                    .q   (seg_in[p])
                );
            end else begin : g_direct
                assign seg_in[p] = seg_out[p-1];
            end
        end
    end

    if (END_LOCKUP) begin : g_tail_lock
        lockup_latch #(.EDGE(LAST_EDG)) u_tail (
            .clk (seg_clk[LAST_SEG]),
            .rst (rst),
            .d   (seg_out[NSEG-1]),
            .q   (scan_out)
        );
    end else begin : g_tail_wire
        assign scan_out = seg_out[NSEG-1];
    end

endmodule

// File: tb/scan_xdom_chain_bench.sv
`timescale 1ns/1ps
module scan_xdom_chain_bench;

    localparam int              CLK_PERIOD = 20;
    localparam int              SAMPLE_AT  = CLK_PERIOD * 4 / 5;
    localparam int              NSEG       = 4;
    localparam int              SEG_LEN    = 3;
    localparam int              NCELL      = NSEG * SEG_LEN;
    localparam logic [NSEG-1:0] FALL_SEGS  = 4'b0101;

    logic [NSEG-1:0]  seg_clk;
    logic             rst, se, si;
    logic [NCELL-1:0] fin, fo_a, fo_b;
    logic             so_a, so_b;
    logic [NCELL-1:0] m_a, m_b;
    int               ord_a [NSEG];
    int               ord_b [NSEG];
    int               n_cmp, n_bad;
    bit               done;

    function automatic int skew_of(int g);
        case (g)
            0:       return 0;
            1:       return 1;
            2:       return 5;
            default: return 5;
        endcase
    endfunction

    for (genvar g = 0; g < NSEG; g++) begin : g_clk
        logic c;
        initial begin
            c = 1'b0;
            #(skew_of(g));
            forever begin
                c = 1'b1;
                #(CLK_PERIOD / 2);
                c = 1'b0;
                #(CLK_PERIOD / 2);
            end
        end
        assign seg_clk[g] = c;
    end

    scan_xdom_chain #(
        .NSEG(NSEG), .SEG_LEN(SEG_LEN), .SEG_FALL(FALL_SEGS),
        .ORDER_BY_EDGE(1'b1), .END_LOCKUP(1'b1)
    ) u_scan_xdom_chain (
        .seg_clk(seg_clk), .rst(rst), .scan_enable(se), .scan_in(si),
        .func_in(fin), .func_out(fo_a), .scan_out(so_a)
    );

    scan_xdom_chain #(
        .NSEG(NSEG), .SEG_LEN(SEG_LEN), .SEG_FALL(FALL_SEGS),
        .ORDER_BY_EDGE(1'b0), .END_LOCKUP(1'b0)
    ) u_scan_xdom_chain_raw (
        .seg_clk(seg_clk), .rst(rst), .scan_enable(se), .scan_in(si),
        .func_in(fin), .func_out(fo_b), .scan_out(so_b)
    );

    function automatic int native_of(int c, bit by_edge);
        int s;
        s = by_edge ? ord_a[c / SEG_LEN] : ord_b[c / SEG_LEN];
        return s * SEG_LEN + (c % SEG_LEN);
    endfunction

    function automatic logic [NCELL-1:0] to_native(logic [NCELL-1:0] m, bit by_edge);
        logic [NCELL-1:0] r;
        r = '0;
        for (int c = 0; c < NCELL; c++) r[native_of(c, by_edge)] = m[c];
        return r;
    endfunction

    task automatic check_bit(string req, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_vec(string req, string what, logic [NCELL-1:0] act, logic [NCELL-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        check_vec(req, "func_out sorted", fo_a, to_native(m_a, 1'b1));
        check_vec(req, "func_out indexed", fo_b, to_native(m_b, 1'b0));
        check_bit(req, "scan_out sorted", so_a, m_a[NCELL-1]);
        check_bit(req, "scan_out indexed", so_b, m_b[NCELL-1]);
    endtask

    // Drive one period and update the chain-order models.
    task automatic step(logic r, logic s_en, logic s_in, logic [NCELL-1:0] f, string req);
        rst = r; se = s_en; si = s_in; fin = f;
        if (r) begin
            m_a = '0; m_b = '0;
        end else if (s_en) begin
            m_a = {m_a[NCELL-2:0], s_in};
            m_b = {m_b[NCELL-2:0], s_in};
        end else begin
            for (int c = 0; c < NCELL; c++) begin
                m_a[c] = f[native_of(c, 1'b1)];
                m_b[c] = f[native_of(c, 1'b0)];
            end
        end
        #(CLK_PERIOD);
        check_all(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int k;
        done = 1'b0; n_cmp = 0; n_bad = 0;
        rst = 1'b1; se = 1'b0; si = 1'b0; fin = '0;
        m_a = '0; m_b = '0;
        k = 0;
        for (int s = 0; s < NSEG; s++) if (FALL_SEGS[s])  begin ord_a[k] = s; k++; end
        for (int s = 0; s < NSEG; s++) if (!FALL_SEGS[s]) begin ord_a[k] = s; k++; end
        for (int s = 0; s < NSEG; s++) ord_b[s] = s;
        void'($urandom(32'd4321));
        #(SAMPLE_AT);

        // R7: reset state.
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, '1, "R7");

        // R2: random stream under skewed clocks.
        for (int i = 0; i < 80; i++) step(1'b0, 1'b1, 1'($urandom), '0, "R2");

        // R1: random capture, then unload.
        step(1'b0, 1'b0, 1'b0, NCELL'($urandom), "R1");
        for (int i = 0; i < 14; i++) step(1'b0, 1'b1, 1'($urandom), '0, "R1");

        // R1: all-ones capture, then alternating stream.
        step(1'b0, 1'b0, 1'b0, '1, "R1");
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'(i % 2), '0, "R2");

        // R1 R4: mixed shift and capture.
        for (int i = 0; i < 150; i++)
            step(1'b0, 1'($urandom), 1'($urandom), NCELL'($urandom), "R1 R4");

        // R7: reset while shifting.
        step(1'b1, 1'b1, 1'b1, '1, "R7");
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'($urandom), '0, "R4");

        // R5 R6: a lone bit reaches the tail after NCELL periods.
        for (int i = 0; i < NCELL; i++) step(1'b0, 1'b1, 1'b0, '0, "R5");
        for (int kk = 1; kk <= NCELL + 2; kk++) begin
            step(1'b0, 1'b1, 1'(kk == 1), '0, "R5");
            check_bit("R5 R6", "lone bit sorted", so_a, 1'(kk == NCELL));
            check_bit("R5", "lone bit indexed", so_b, 1'(kk == NCELL));
        end

        // R3 R4: captured bit of segment 2, cell 0 (bit 6) exits after
        // 8 shifts in sorted order (position 3), 5 in index order (position 6).
        for (int i = 0; i < NCELL; i++) step(1'b0, 1'b1, 1'b0, '0, "R3");
        step(1'b0, 1'b0, 1'b0, NCELL'(1) << 6, "R1");
        for (int j = 1; j <= NCELL; j++) begin
            step(1'b0, 1'b1, 1'b0, '0, "R3");
            check_bit("R3", "segment order sorted", so_a, 1'(j == 8));
            check_bit("R4", "segment order indexed", so_b, 1'(j == 5));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule